// File: doc/BRIEF.md
# Receive Frame FIFO

This block sits between an Ethernet receive datapath and a host. Frames arrive as a byte stream. The block packs each frame into 32-bit words in a local buffer and puts two words in front of it. The first is a fixed marker. The second is a header that packs the byte length with error status. The host drains the buffer one word at a time through a single data register, so it only needs a plain register read/write port. Another register reports how many complete frames are waiting.

A frame becomes visible to the host only once it has been fully stored. The block drops the whole frame if any of these holds:

- reception was disabled when the frame started;
- the buffer lacks room for all of it;
- a flush interrupted it.

A host that reads something other than the marker where a frame should begin has lost alignment. It recovers by setting the flush bit, which discards everything buffered.

The ingress side is a valid/ready stream. A byte moves on a rising clock edge where `in_valid` and `in_ready` are both high. The block never back-pressures to avoid loss. It lowers `in_ready` only during the two trailer cycles after each stored frame's last byte and during the single flush cycle. A source must hold its byte, last flag and error flags stable while `in_valid` is high and `in_ready` is low. The buffer depth `DEPTH_BYTES` must be a power of two, four or more times the word size.

Top module: `rx_frame_fifo`

## Requirements
- R1: For each stored frame, the first word read from the data register (address 2) is 0x0143414D.
- R2: The second word carries the frame's byte count in bits 15:0. Bits 31:16 carry status, and only three status bits can be set. Status bit 4 is set when the last beat had `in_crc_err`. Status bits 6:5 are both set when the last beat had `in_len_err`. Every other status bit is zero.
- R3: After the header come ceil(length/4) payload words. Byte k of the frame lands in word k/4, at bits 8*(k%4)+7 down to 8*(k%4). Byte positions past the frame's end read as zero.
- R4: The frame-count register (address 3) rises by one two cycles after a stored frame's last byte is accepted. It falls by one when the host reads that frame's last payload word.
- R5: Writing zero to the frame-count register clears it. Writing a nonzero value leaves it unchanged.
- R6: Writing 1 to bit 3 of the receive-config register (address 1) starts a flush. That bit reads back as 1 in the next cycle and as 0 afterwards. The flush empties the buffer and zeroes the frame count. The bytes that remain of a frame caught mid-arrival are discarded.
- R7: Bit 2 of the control register (address 0) enables reception and reads back as written. A frame whose first byte arrives while this bit is clear is discarded in full.
- R8: Frames shorter than 64 bytes, down to one byte, are stored and counted like any other frame.
- R9: A frame that does not fit in the free space is discarded in full. The frame count is unchanged and the frames already buffered read back intact. A later frame that fits is stored.
- R10: Reading the data register while no complete frame data is buffered returns zero and consumes nothing.
- R11: `in_ready` is low for the two cycles after a stored frame's last byte is accepted, then high again.
- R12: After reset, reception is disabled, the frame count and the flush bit read zero, the data register reads zero, and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Ingress byte valid |
| in_ready | output | 1 | Block can accept a byte |
| in_data | input | 8 | Ingress byte |
| in_last | input | 1 | Byte is the last of its frame |
| in_crc_err | input | 1 | CRC error flag, taken from the last beat |
| in_len_err | input | 1 | Length error flag, taken from the last beat |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe; a read of address 2 consumes a word |
| host_addr | input | 2 | Register select: 0 control, 1 receive config, 2 data, 3 frame count |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Register read data, valid in the cycle of the read strobe |

## Verification
The bench fills the buffer until a frame overruns the free space. A design that kept part of that frame, or counted it, would corrupt the next marker or report a phantom frame. It also flushes partway through an arriving frame and then sends the rest of that frame. A writer that did not keep discarding would store the tail as a bogus frame in front of the good one that follows. Further runs cover one-byte and odd-length runts, which would expose wrong word rounding or stale bytes in the padding. They also cover a frame sent with reception off and a nonzero write to the count register, either of which a sloppy design would let change the stored state.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam logic [31:0] FRAME_MARK = 32'h0143414D;
  localparam int EN_BIT    = 2;
  localparam int FLUSH_BIT = 3;

  typedef enum logic [1:0] {
    A_CTRL  = 2'd0,
    A_RXCFG = 2'd1,
    A_DATA  = 2'd2,
    A_FCNT  = 2'd3
  } reg_addr_e;

  typedef enum logic [2:0] {
    W_IDLE, W_RUN, W_DROP, W_MARK, W_HDR
  } wr_state_e;

  typedef enum logic [1:0] {
    R_MARK, R_HDR, R_PAY
  } rd_phase_e;
endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int NWORDS = 1024,
  localparam int AW = $clog2(NWORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rdata
);
  logic [31:0] mem [NWORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rxf_writer.sv
module rxf_writer
  import rxf_pkg::*;
#(
  parameter int NWORDS = 1024,
  localparam int AW = $clog2(NWORDS),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          rx_en,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  input  logic          in_crc_err,
  input  logic          in_len_err,
  input  logic [PW-1:0] rptr,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [31:0]   mem_wdata,
  output logic [PW-1:0] commit_ptr,
  output logic          frame_done
);
  wr_state_e     state_q;
  logic [PW-1:0] cwp_q, tp_q;
  logic [31:0]   acc_q;
  logic [15:0]   bcnt_q;
  logic          ovf_q, crc_q, lerr_q;

  logic          accept, start_ok, pay_room, word_end, ovf_n;
  logic [1:0]    lane;
  logic [31:0]   word_c;
  logic [PW-1:0] used_c, hdr_ptr;

  assign in_ready = (state_q != W_MARK) && (state_q != W_HDR) && !flush;
  assign accept   = in_valid && in_ready;
  assign lane     = (state_q == W_RUN) ? bcnt_q[1:0] : 2'd0;
  assign word_c   = ((lane == 2'd0) ? 32'd0 : acc_q) | (32'(in_data) << {lane, 3'b000});
  assign used_c   = cwp_q - rptr;
  assign start_ok = rx_en && (used_c <= PW'(NWORDS - 3));
  assign pay_room = (tp_q - rptr) < PW'(NWORDS);
  assign word_end = (lane == 2'd3) || in_last;
  assign ovf_n    = ovf_q || (word_end && !pay_room);
  assign hdr_ptr  = cwp_q + PW'(1);

  assign commit_ptr = cwp_q;
  assign frame_done = (state_q == W_HDR) && !flush;

  // single write port: payload words during the frame, then marker, then header
  always_comb begin
    mem_we    = 1'b0;
    mem_waddr = tp_q[AW-1:0];
    mem_wdata = word_c;
    unique case (state_q)
      W_IDLE: if (accept && start_ok && in_last) begin
        mem_we    = 1'b1;
        mem_waddr = cwp_q[AW-1:0] + AW'(2);
      end
      W_RUN: if (accept && word_end && !ovf_q && pay_room) mem_we = 1'b1;
      W_MARK: begin
        mem_we    = 1'b1;
        mem_waddr = cwp_q[AW-1:0];
        mem_wdata = FRAME_MARK;
      end
      W_HDR: begin
        mem_we    = 1'b1;
        mem_waddr = hdr_ptr[AW-1:0];
        mem_wdata = {9'd0, lerr_q ? 2'b11 : 2'b00, crc_q, 4'd0, bcnt_q};
      end
      default: mem_we = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= W_IDLE;
      cwp_q   <= '0;
      tp_q    <= '0;
      acc_q   <= '0;
      bcnt_q  <= '0;
      ovf_q   <= 1'b0;
      crc_q   <= 1'b0;
      lerr_q  <= 1'b0;
    end else if (flush) begin
      cwp_q   <= '0;
      tp_q    <= '0;
      state_q <= (state_q == W_RUN || state_q == W_DROP) ? W_DROP : W_IDLE;
    end else begin
      unique case (state_q)
        W_IDLE: if (accept) begin
          if (start_ok) begin
            bcnt_q <= 16'd1;
            acc_q  <= word_c;
            ovf_q  <= 1'b0;
            crc_q  <= in_crc_err;
            lerr_q <= in_len_err;
            if (in_last) begin
              tp_q    <= cwp_q + PW'(3);
              state_q <= W_MARK;
            end else begin
              tp_q    <= cwp_q + PW'(2);
              state_q <= W_RUN;
            end
          end else begin
            state_q <= in_last ? W_IDLE : W_DROP;
          end
        end
        W_RUN: if (accept) begin
          bcnt_q <= bcnt_q + 16'd1;
          crc_q  <= in_crc_err;
          lerr_q <= in_len_err;
          ovf_q  <= ovf_n;
          if (word_end) begin
            acc_q <= '0;
            if (!ovf_n) tp_q <= tp_q + PW'(1);
          end else begin
            acc_q <= word_c;
          end
          if (in_last) state_q <= ovf_n ? W_IDLE : W_MARK;
        end
        W_DROP: if (accept && in_last) state_q <= W_IDLE;
        W_MARK: state_q <= W_HDR;
        W_HDR: begin
          cwp_q   <= tp_q;
          state_q <= W_IDLE;
        end
        default: state_q <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxf_reader.sv
module rxf_reader
  import rxf_pkg::*;
#(
  parameter int NWORDS = 1024,
  localparam int AW = $clog2(NWORDS),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          pop,
  input  logic [PW-1:0] commit_ptr,
  input  logic [31:0]   mem_rdata,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rptr,
  output logic [31:0]   rd_word,
  output logic          empty,
  output logic          frame_read,
  output rd_phase_e     phase
);
  logic [15:0] left_q, hdr_words;
  logic        take;

  assign raddr     = rptr[AW-1:0];
  assign empty     = (rptr == commit_ptr);
  assign rd_word   = empty ? 32'd0 : mem_rdata;
  assign take      = pop && !empty && !flush;
  assign hdr_words = {2'b00, mem_rdata[15:2]} + 16'(|mem_rdata[1:0]);
  assign frame_read = take && (((phase == R_PAY) && (left_q == 16'd1)) ||
                               ((phase == R_HDR) && (hdr_words == 16'd0)));

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      rptr   <= '0;
      phase  <= R_MARK;
      left_q <= '0;
    end else if (take) begin
      rptr <= rptr + PW'(1);
      unique case (phase)
        R_MARK: phase <= R_HDR;
        R_HDR: begin
          left_q <= hdr_words;
          phase  <= (hdr_words == 16'd0) ? R_MARK : R_PAY;
        end
        R_PAY: begin
          left_q <= left_q - 16'd1;
          if (left_q == 16'd1) phase <= R_MARK;
        end
        default: phase <= R_MARK;
      endcase
    end
  end
endmodule

// File: rtl/rx_frame_fifo.sv
module rx_frame_fifo
  import rxf_pkg::*;
#(
  parameter int DEPTH_BYTES = 4096
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  input  logic        in_crc_err,
  input  logic        in_len_err,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic [1:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata
);
  localparam int NWORDS = DEPTH_BYTES / 4;
  localparam int AW     = $clog2(NWORDS);
  localparam int PW     = AW + 1;

  logic          rx_en_q, flushing_q;
  logic [PW-1:0] fcount_q;
  logic          clr_c, pop, frame_done, frame_read, empty, mem_we;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [31:0]   mem_wdata, mem_rdata, rd_word;
  logic [PW-1:0] commit_ptr, rptr;
  rd_phase_e     rd_phase;

  assign clr_c = host_wr && (reg_addr_e'(host_addr) == A_FCNT) && (host_wdata == 32'd0);
  assign pop   = host_rd && (reg_addr_e'(host_addr) == A_DATA) && !flushing_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_en_q    <= 1'b0;
      flushing_q <= 1'b0;
    end else begin
      if (host_wr && reg_addr_e'(host_addr) == A_CTRL) rx_en_q <= host_wdata[EN_BIT];
      flushing_q <= host_wr && (reg_addr_e'(host_addr) == A_RXCFG) && host_wdata[FLUSH_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flushing_q || clr_c) fcount_q <= '0;
    else fcount_q <= fcount_q + PW'(frame_done) - PW'(frame_read && (fcount_q != '0));
  end

  always_comb begin
    unique case (reg_addr_e'(host_addr))
      A_CTRL:  host_rdata = 32'(rx_en_q) << EN_BIT;
      A_RXCFG: host_rdata = 32'(flushing_q) << FLUSH_BIT;
      A_DATA:  host_rdata = rd_word;
      A_FCNT:  host_rdata = 32'(fcount_q);
      default: host_rdata = 32'd0;
    endcase
  end

  rxf_writer #(.NWORDS(NWORDS)) u_wr (
    .clk(clk), .rst_n(rst_n), .flush(flushing_q), .rx_en(rx_en_q),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last(in_last), .in_crc_err(in_crc_err), .in_len_err(in_len_err),
    .rptr(rptr), .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .commit_ptr(commit_ptr), .frame_done(frame_done)
  );

  rxf_store #(.NWORDS(NWORDS)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );

  rxf_reader #(.NWORDS(NWORDS)) u_rd (
    .clk(clk), .rst_n(rst_n), .flush(flushing_q), .pop(pop),
    .commit_ptr(commit_ptr), .mem_rdata(mem_rdata), .raddr(mem_raddr),
    .rptr(rptr), .rd_word(rd_word), .empty(empty),
    .frame_read(frame_read), .phase(rd_phase)
  );
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker
  import rxf_pkg::*;
#(
  parameter int NWORDS = 1024,
  localparam int PW = $clog2(NWORDS) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flushing,
  input logic          clr,
  input logic [PW-1:0] fcount,
  input logic          empty,
  input logic [PW-1:0] commit_ptr,
  input logic [PW-1:0] rptr,
  input logic [1:0]    rd_phase,
  input logic [31:0]   mem_rdata
);
  AST_MARK_AT_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && rd_phase == R_MARK) |-> (mem_rdata == FRAME_MARK)); // R1

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (PW'(commit_ptr - rptr) <= PW'(NWORDS))); // R9

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flushing |=> (empty && fcount == '0)); // R6

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!flushing && !clr) |=> ((fcount == $past(fcount)) ||
                             (fcount == $past(fcount) + PW'(1)) ||
                             (fcount + PW'(1) == $past(fcount)))); // R4

  AST_PENDING_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (fcount != '0) |-> !empty); // R4
endmodule

bind rx_frame_fifo rxf_checker #(.NWORDS(NWORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .flushing(flushing_q), .clr(clr_c),
  .fcount(fcount_q), .empty(empty), .commit_ptr(commit_ptr), .rptr(rptr),
  .rd_phase(rd_phase), .mem_rdata(mem_rdata)
);

// File: tb/rx_frame_fifo_test.sv
module rx_frame_fifo_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] MARK = 32'h0143414D;
  localparam int NV = 4;
  // stimulus columns: length, crc flag, length-error flag, seed; expected column: status half
  localparam int          TV_LEN  [NV] = '{64, 5, 1, 130};
  localparam bit          TV_CRC  [NV] = '{1'b0, 1'b1, 1'b0, 1'b1};
  localparam bit          TV_LE   [NV] = '{1'b0, 1'b0, 1'b1, 1'b1};
  localparam logic [7:0]  TV_SEED [NV] = '{8'h10, 8'hF0, 8'h5A, 8'h81};
  localparam logic [15:0] TV_STAT [NV] = '{16'h0000, 16'h0010, 16'h0060, 16'h0070};

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, in_last = 1'b0, in_crc_err = 1'b0, in_len_err = 1'b0;
  logic [7:0] in_data = 8'd0;
  logic host_wr = 1'b0, host_rd = 1'b0;
  logic [1:0] host_addr = 2'd0;
  logic [31:0] host_wdata = 32'd0, host_rdata, v;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_frame_fifo uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .in_crc_err(in_crc_err),
    .in_len_err(in_len_err), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic host_read(logic [1:0] a, output logic [31:0] r);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    #1 r = host_rdata;
    @(posedge clk);
    #1 host_rd = 1'b0;
  endtask

  task automatic host_write(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(posedge clk);
    #1 host_wr = 1'b0;
  endtask

  task automatic send_byte(logic [7:0] d, bit last, bit crc, bit le);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_last = last; in_crc_err = crc; in_len_err = le;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0; in_last = 1'b0; in_crc_err = 1'b0; in_len_err = 1'b0;
  endtask

  // returns at the negedge that follows acceptance of the last byte
  task automatic send_frame(int len, bit crc, bit le, logic [7:0] seed);
    @(negedge clk);
    for (int i = 0; i < len; i++) begin
      in_valid = 1'b1; in_data = seed + 8'(i); in_last = (i == len - 1);
      in_crc_err = crc; in_len_err = le;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0; in_last = 1'b0; in_crc_err = 1'b0; in_len_err = 1'b0;
  endtask

  task automatic read_frame(string tag, int len, logic [15:0] stat, logic [7:0] seed);
    logic [31:0] r;
    host_read(2'd2, r); check({tag, " R1 marker"}, r, MARK);
    host_read(2'd2, r); check({tag, " R2 header"}, r, {stat, 16'(len)});
    for (int w = 0; w < (len + 3) / 4; w++) begin
      logic [31:0] e = 32'd0;
      for (int b = 0; b < 4; b++)
        if (4 * w + b < len) e |= 32'(8'(seed + 8'(4 * w + b))) << (8 * b);
      host_read(2'd2, r); check({tag, " R3 payload"}, r, e);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R12 reset state
    #1 check("R12 in_ready", 32'(in_ready), 32'd1);
    host_read(2'd0, v); check("R12 ctrl", v, 32'd0);
    host_read(2'd1, v); check("R12 rxcfg", v, 32'd0);
    host_read(2'd3, v); check("R12 count", v, 32'd0);
    host_read(2'd2, v); check("R12 data", v, 32'd0);
    host_write(2'd0, 32'd4);
    host_read(2'd0, v); check("R7 enable readback", v, 32'd4);

    // table walk: R1 R2 R3 R4 R8 R11
    for (int t = 0; t < NV; t++) begin
      send_frame(TV_LEN[t], TV_CRC[t], TV_LE[t], TV_SEED[t]);
      check("R11 trailer 1", 32'(in_ready), 32'd0);
      @(negedge clk); check("R11 trailer 2", 32'(in_ready), 32'd0);
      @(negedge clk); check("R11 ready again", 32'(in_ready), 32'd1);
      host_read(2'd3, v); check("R4 count up", v, 32'd1);
      read_frame("R8 vec", TV_LEN[t], TV_STAT[t], TV_SEED[t]);
      host_read(2'd3, v); check("R4 count down", v, 32'd0);
    end

    // R10 empty read
    host_read(2'd2, v); check("R10 empty data", v, 32'd0);

    // R7 disabled reception
    host_write(2'd0, 32'd0);
    host_read(2'd0, v); check("R7 disable readback", v, 32'd0);
    send_frame(20, 1'b0, 1'b0, 8'h33);
    repeat (3) @(negedge clk);
    host_read(2'd3, v); check("R7 no count", v, 32'd0);
    host_read(2'd2, v); check("R7 no data", v, 32'd0);
    host_write(2'd0, 32'd4);

    // R5 count clear semantics
    send_frame(8, 1'b0, 1'b0, 8'h40);
    repeat (3) @(negedge clk);
    host_write(2'd3, 32'd5);
    host_read(2'd3, v); check("R5 nonzero write ignored", v, 32'd1);
    host_write(2'd3, 32'd0);
    host_read(2'd3, v); check("R5 zero clears", v, 32'd0);
    host_read(2'd2, v); check("R5 data kept", v, MARK);

    // R6 flush with a partial frame arriving
    for (int i = 0; i < 6; i++) send_byte(8'(i), 1'b0, 1'b0, 1'b0);
    host_write(2'd1, 32'd8);
    host_read(2'd1, v); check("R6 busy bit", v, 32'd8);
    host_read(2'd1, v); check("R6 self clear", v, 32'd0);
    host_read(2'd3, v); check("R6 count zero", v, 32'd0);
    host_read(2'd2, v); check("R6 buffer empty", v, 32'd0);
    for (int i = 0; i < 4; i++) send_byte(8'hE0 + 8'(i), i == 3, 1'b0, 1'b0);
    send_frame(9, 1'b0, 1'b0, 8'h77);
    repeat (3) @(negedge clk);
    host_read(2'd3, v); check("R6 tail dropped count", v, 32'd1);
    read_frame("R6 after flush", 9, 16'h0000, 8'h77);

    // R9 overflow: 2 x 502 words stored, third does not fit, fourth fits
    send_frame(2000, 1'b0, 1'b0, 8'h01);
    send_frame(2000, 1'b0, 1'b0, 8'h02);
    send_frame(2000, 1'b0, 1'b0, 8'h03);
    send_frame(40, 1'b1, 1'b0, 8'h04);
    repeat (3) @(negedge clk);
    host_read(2'd3, v); check("R9 count", v, 32'd3);
    read_frame("R9 first", 2000, 16'h0000, 8'h01);
    read_frame("R9 second", 2000, 16'h0000, 8'h02);
    read_frame("R9 small after drop", 40, 16'h0010, 8'h04);
    host_read(2'd3, v); check("R9 drained", v, 32'd0);
    host_read(2'd2, v); check("R10 empty after drain", v, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule